// File: doc/BRIEF.md
# Priority Interrupt Vector Resolver

This block sits behind the line-capture logic of an interrupt controller. It receives pending, mask, fast-class select and priority values for up to three banks of 32 lines. For each of the two interrupt classes, normal and fast, it picks one winning line and places that line's number in a registered vector. It also raises a registered request toward the processor.

Each class has an agreement flag. A request is raised only while the flag is set, and raising the request clears the flag. The request and its vector then stay frozen until software sends a rearm pulse for that class. A rearm sets the flag again and re-evaluates the class in the same cycle. If an eligible line is present at that moment, the request stays high and the vector moves to the new winner. A global enable input holds back every new request.

Top module: `pvr_top`

## Requirements
- R1: A line competes for a class only when its pending bit is 1 and its mask bit is 0. Its select bit must also match the class: 0 selects the normal class and 1 selects the fast class.
- R2: Among eligible lines, the one with the numerically smallest priority value wins. Priority 0 is the most urgent.
- R3: When eligible lines share the smallest priority, the line with the larger global index wins. The global index is 32 × bank + bit, which is the bit position in the flat input vectors.
- R4: A rearm of a class that has no eligible line clears that class's request and sets its vector to 0 on the next clock edge.
- R5: When a class's agreement flag is set, an eligible line exists and the global enable is 1, the request rises on the next clock edge. In that same edge the vector takes the winner's index.
- R6: While a request is high and no rearm arrives for its class, the request and the vector hold, whatever the inputs do.
- R7: While the global enable is 0, no request rises. Once the enable returns to 1, a pending agreement raises its request.
- R8: A rearm with an eligible line present keeps the request high and loads the current winner's index on the next edge.
- R9: After reset, both requests are 0, both vectors are 0 and both agreement flags are set.
- R10: The two classes resolve and rearm independently. A rearm bit affects only its own class: bit 0 is the normal class and bit 1 is the fast class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 96 | Pending bit per line (global index order) |
| mask_i | input | 96 | Mask bit per line, 1 blocks the line |
| fsel_i | input | 96 | Class select per line, 1 = fast class |
| prio_i | input | 576 | Priority per line, line i at bits [i*6 +: 6] |
| glb_en_i | input | 1 | Global enable for new requests |
| rearm_i | input | 2 | Rearm pulse per class, bit 0 normal, bit 1 fast |
| req_o | output | 2 | Registered request per class, bit 0 normal, bit 1 fast |
| vec_irq_o | output | 7 | Latched winning line for the normal class |
| vec_fiq_o | output | 7 | Latched winning line for the fast class |

## Verification
The resolver is driven with several kinds of line pattern, and each one tells apart a different wrong behaviour:
- A single pending line shows the basic raise path.
- Lines of different priority, where the lower-numbered line is the less urgent one, separate a priority compare from an index compare.
- Equal priorities in different banks, including the index extremes 0 and 94, expose a reversed tie-break.
- A masked line, and lines that are pending in the opposite class, show whether the eligibility filter is applied.
- Held requests meeting new, more urgent lines, single-class rearms, a rearm with nothing eligible, and a cycle with the global enable dropped exercise the handshake separately from the search.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  localparam int unsigned DEF_BANKS  = 3;
  localparam int unsigned DEF_BANK_W = 32;
  localparam int unsigned DEF_PRIO_W = 6;

  typedef enum logic {
    CLS_NORMAL = 1'b0,
    CLS_FAST   = 1'b1
  } pvr_class_e;
endpackage

// File: rtl/pvr_select.sv
module pvr_select #(
  parameter int unsigned NL     = 96,
  parameter int unsigned PW     = 6,
  parameter bit          IS_FIQ = 1'b0,
  localparam int unsigned VW    = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NL-1:0]     pend_i,
  input  logic [NL-1:0]     mask_i,
  input  logic [NL-1:0]     fsel_i,
  input  logic [NL*PW-1:0]  prio_i,
  output logic              any_o,
  output logic [VW-1:0]     win_o
);
  logic [NL-1:0] elig;
  logic [PW-1:0] best_p;

  // class filter chosen by parameter
  generate
    if (IS_FIQ) begin : g_fast
      assign elig = pend_i & ~mask_i & fsel_i;
    end else begin : g_norm
      assign elig = pend_i & ~mask_i & ~fsel_i;
    end
  endgenerate

  // ascending scan; "<=" lets a later (higher) index take an equal priority
  always_comb begin
    any_o  = 1'b0;
    best_p = '1;
    win_o  = '0;
    for (int i = 0; i < NL; i++) begin
      if (elig[i] && (!any_o || prio_i[i*PW +: PW] <= best_p)) begin
        any_o  = 1'b1;
        best_p = prio_i[i*PW +: PW];
        win_o  = VW'(i);
      end
    end
  end

  assert_win_eligible_R1: assert property (@(posedge clk) disable iff (rst)
    any_o |-> elig[win_o]);
  assert_none_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !any_o |-> (win_o == '0));
endmodule

// File: rtl/pvr_class_ctrl.sv
module pvr_class_ctrl #(
  parameter int unsigned VW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rearm_i,
  input  logic          glb_en_i,
  input  logic          any_i,
  input  logic [VW-1:0] win_i,
  output logic          req_o,
  output logic [VW-1:0] vec_o
);
  logic agree_q;
  logic fire;

  assign fire = any_i && glb_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      agree_q <= 1'b1;
      vec_o   <= '0;
    end else if (rearm_i) begin
      vec_o <= win_i;
      if (fire) begin
        req_o   <= 1'b1;
        agree_q <= 1'b0;
      end else begin
        req_o   <= 1'b0;
        agree_q <= 1'b1;
      end
    end else if (agree_q && fire) begin
      req_o   <= 1'b1;
      agree_q <= 1'b0;
      vec_o   <= win_i;
    end
  end

  assert_raise_R5: assert property (@(posedge clk) disable iff (rst)
    (agree_q && any_i && glb_en_i && !rearm_i) |=> (req_o && vec_o == $past(win_i)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_o && !rearm_i) |=> (req_o && $stable(vec_o)));
  assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> !$rose(req_o));
  assert_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (rearm_i && !any_i) |=> (!req_o && vec_o == '0));
  assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (rearm_i && any_i && glb_en_i) |=> (req_o && vec_o == $past(win_i)));
endmodule

// File: rtl/pvr_top.sv
module pvr_top #(
  parameter int unsigned BANKS  = pvr_pkg::DEF_BANKS,
  parameter int unsigned BANK_W = pvr_pkg::DEF_BANK_W,
  parameter int unsigned PW     = pvr_pkg::DEF_PRIO_W,
  localparam int unsigned NL    = BANKS * BANK_W,
  localparam int unsigned VW    = $clog2(NL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NL-1:0]    pend_i,
  input  logic [NL-1:0]    mask_i,
  input  logic [NL-1:0]    fsel_i,
  input  logic [NL*PW-1:0] prio_i,
  input  logic             glb_en_i,
  input  logic [1:0]       rearm_i,
  output logic [1:0]       req_o,
  output logic [VW-1:0]    vec_irq_o,
  output logic [VW-1:0]    vec_fiq_o
);
  logic [1:0]          any_w;
  logic [1:0][VW-1:0]  win_w;
  logic [1:0][VW-1:0]  vec_w;

  generate
    for (genvar c = 0; c < 2; c++) begin : g_cls
      pvr_select #(.NL(NL), .PW(PW), .IS_FIQ(c == int'(pvr_pkg::CLS_FAST))) u_sel (
        .clk(clk), .rst(rst),
        .pend_i(pend_i), .mask_i(mask_i), .fsel_i(fsel_i), .prio_i(prio_i),
        .any_o(any_w[c]), .win_o(win_w[c])
      );
      pvr_class_ctrl #(.VW(VW)) u_ctl (
        .clk(clk), .rst(rst),
        .rearm_i(rearm_i[c]), .glb_en_i(glb_en_i),
        .any_i(any_w[c]), .win_i(win_w[c]),
        .req_o(req_o[c]), .vec_o(vec_w[c])
      );
    end
  endgenerate

  assign vec_irq_o = vec_w[pvr_pkg::CLS_NORMAL];
  assign vec_fiq_o = vec_w[pvr_pkg::CLS_FAST];

  assert_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> (req_o == 2'b00 && vec_irq_o == '0 && vec_fiq_o == '0));
endmodule

// File: tb/tb_pvr_top.sv
module tb_pvr_top;
  localparam int NL = 96;
  localparam int PW = 6;

  typedef struct {
    logic [1:0] req;
    logic [6:0] vi;
    logic [6:0] vf;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NL-1:0]    pend = '0, mask = '0, fsel = '0;
  logic [NL*PW-1:0] prio = '0;
  logic             glb_en = 1'b1;
  logic [1:0]       rearm = 2'b00;
  logic [1:0]       req;
  logic [6:0]       vec_irq, vec_fiq;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pvr_top dut (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask), .fsel_i(fsel),
    .prio_i(prio), .glb_en_i(glb_en), .rearm_i(rearm),
    .req_o(req), .vec_irq_o(vec_irq), .vec_fiq_o(vec_fiq)
  );

  // monitor: compare registered outputs half a cycle after each edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (req !== e.req || vec_irq !== e.vi || vec_fiq !== e.vf) begin
        n_errors++;
        $display("FAIL %s: actual req=%b irq=%0d fiq=%0d expected req=%b irq=%0d fiq=%0d",
                 e.tag, req, vec_irq, vec_fiq, e.req, e.vi, e.vf);
      end
    end
  end

  task automatic set_line(input int idx, input logic p, input logic f, input int pr);
    pend[idx] = p;
    fsel[idx] = f;
    prio[idx*PW +: PW] = PW'(pr);
  endtask

  // driver: one clock edge, then push what the requirements predict
  task automatic step(input string tag, input logic [1:0] er, input int evi, input int evf);
    exp_t e;
    @(posedge clk);
    e.req = er; e.vi = 7'(evi); e.vf = 7'(evf); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    rearm = 2'b00;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step("R9 reset state", 2'b00, 0, 0);
    set_line(5, 1, 0, 10);
    step("R5 single line raises", 2'b01, 5, 0);
    set_line(40, 1, 0, 3);
    step("R6 held while agreement clear", 2'b01, 5, 0);
    rearm = 2'b01;
    step("R8 R2 rearm picks lower priority", 2'b01, 40, 0);
    set_line(70, 1, 0, 3); rearm = 2'b01;
    step("R3 tie goes to higher index", 2'b01, 70, 0);
    mask[70] = 1'b1; rearm = 2'b01;
    step("R1 masked line ignored", 2'b01, 40, 0);
    pend = '0; rearm = 2'b01;
    step("R4 rearm with none eligible", 2'b00, 0, 0);
    glb_en = 1'b0; set_line(10, 1, 1, 2); set_line(11, 1, 0, 2);
    step("R7 global enable blocks", 2'b00, 0, 0);
    glb_en = 1'b1;
    step("R7 R10 R1 both classes raise", 2'b11, 11, 10);
    set_line(95, 1, 1, 0); rearm = 2'b10;
    step("R10 R2 fast rearm only", 2'b11, 11, 95);
    pend[11] = 1'b0; rearm = 2'b01;
    step("R10 R4 normal rearm empty", 2'b10, 0, 95);
    set_line(0, 1, 0, 63);
    step("R5 index zero max priority", 2'b11, 0, 95);
    prio[0*PW +: PW] = 6'd62; set_line(94, 1, 0, 63); rearm = 2'b01;
    step("R2 priority beats index", 2'b11, 0, 95);
    prio[0*PW +: PW] = 6'd63; rearm = 2'b01;
    step("R3 tie index 94 over 0", 2'b11, 94, 95);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule